// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block runs counted loops for a small in-order core so that software pays no branch instruction at the bottom of a loop body. The core reports each loop-setup instruction with its own PC, an end offset and an iteration count. The count comes from one of two sources: an immediate, which is biased by one, or the low bits of a register value. The controller records the first body address, the loop-end address and the number of passes still to run, and raises a busy flag. On every later fetch it computes the next PC at once. When the sequential successor of the current PC equals the stored loop end, it sends fetch back to the loop top until the passes run out. It then lets execution fall through to the loop end.

The setup instruction has a second variant, the interruptible loop, which may be cancelled by an abort input. A cancelled loop drops its busy flag and resumes at the loop end. A register count of zero starts no loop: it sends the PC straight to the stored loop end. The redirect is combinational from the fetch PC and the stored state, so each pass costs no extra cycle. Only one loop is held. A new setup instruction replaces whatever loop is active.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, busy_o is 0, the stored loop end is address 0, and next_pc_o equals pc_i+1 modulo 2^PC_W.
- R2: With cnt_imm_sel_i=1, the loop runs cnt_imm_i+1 passes. From the setup cycle until the PC reaches the loop end, exactly 1+(cnt_imm_i+1)*(end_offs_i-1) fetch cycles elapse.
- R3: With cnt_imm_sel_i=0, the pass count is cnt_reg_i modulo 2^CNT_W. Bits above CNT_W are ignored.
- R4: A setup cycle whose count is zero drives next_pc_o to the stored loop end. It changes no stored state, and busy_o keeps its value.
- R5: A setup cycle with a nonzero count drives next_pc_o to pc_i+1 and raises busy_o from the next cycle. It stores the loop top as pc_i+1, the loop end as pc_i+end_offs_i (zero-extended, modulo 2^PC_W), the count, and the variant taken from loop_intr_i.
- R6: While busy_o is 1 and pc_i+1 equals the loop end, with more than one pass remaining, next_pc_o is the loop top in that same cycle, and the remaining count drops by one.
- R7: When the last pass reaches the loop end, next_pc_o is pc_i+1 (the loop end), and busy_o is 0 from the next cycle.
- R8: For an interruptible loop, abort_i=1 in a cycle with no setup drives next_pc_o to the loop end, and busy_o is 0 from the next cycle.
- R9: For a plain loop, abort_i has no effect: the loop keeps its pass count and completes as in R2 and R3.
- R10: A setup cycle has priority over the loop-end redirect and over abort. A setup while busy replaces the active loop.
- R11: A cycle with no setup, no end match and no accepted abort gives next_pc_o = pc_i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_start_i | input | 1 | A loop-setup instruction executes this cycle |
| loop_intr_i | input | 1 | Setup is the interruptible variant |
| cnt_imm_sel_i | input | 1 | 1: count is immediate+1; 0: count is register low bits |
| cnt_imm_i | input | IMM_W | Immediate count field |
| cnt_reg_i | input | REG_W | Register value supplying the count |
| end_offs_i | input | OFFS_W | Loop-end offset from the setup PC |
| pc_i | input | PC_W | PC of the instruction executing this cycle |
| abort_i | input | 1 | Cancel request for an interruptible loop |
| next_pc_o | output | PC_W | PC to fetch next |
| busy_o | output | 1 | A loop is in progress |

## Verification
The bench builds the block with PC_W=8, OFFS_W=4, IMM_W=3, CNT_W=5 and REG_W=8. At these sizes every immediate count and every offset from 2 to 15 can be swept in full. Every register count from 0 to 31 is also reached, each with and without the ignored upper register bits set. The 8-bit PC lets loop ends wrap past address 255. An abort is placed at each cycle of an interruptible loop's run. Setup is also issued on a loop-end cycle while another loop is active, together with an abort.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

   // Source selected for the next fetch address
   typedef enum logic [1:0] {
      PC_SEQ = 2'd0,
      PC_TOP = 2'd1,
      PC_END = 2'd2
   } pc_src_t;

endpackage

// File: rtl/hwloop_count_sel.sv
module hwloop_count_sel #(
   parameter int IMM_W = 8,
   parameter int CNT_W = 16,
   parameter int REG_W = 32
) (
   input  logic             imm_sel_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [REG_W-1:0] reg_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cnt_zero_o
);

   logic [CNT_W-1:0] imm_cnt;
   logic [CNT_W-1:0] reg_cnt;

   // immediate form is biased by one so it can never be zero
   assign imm_cnt = CNT_W'(imm_i) + CNT_W'(1);
   assign reg_cnt = reg_i[CNT_W-1:0];

   generate
      if (REG_W > CNT_W) begin : g_hi_bits
         logic unused_reg_hi;
         assign unused_reg_hi = ^reg_i[REG_W-1:CNT_W];
      end
   endgenerate

   assign cnt_o      = imm_sel_i ? imm_cnt : reg_cnt;
   assign cnt_zero_o = (cnt_o == '0);

endmodule

// File: rtl/hwloop_decide.sv
module hwloop_decide
   import hwloop_pkg::*;
#(
   parameter int PC_W     = 16,
   parameter int CNT_W    = 16,
   parameter bit ABORT_EN = 1'b1
) (
   input  logic             start_i,
   input  logic             cnt_zero_i,
   input  logic             abort_i,
   input  logic             act_q_i,
   input  logic             intr_q_i,
   input  logic [PC_W-1:0]  seq_pc_i,
   input  logic [PC_W-1:0]  end_q_i,
   input  logic [CNT_W-1:0] cnt_q_i,
   output pc_src_t          src_o,
   output logic             load_o,
   output logic             dec_o,
   output logic             clr_o
);

   logic abort_hit;
   logic end_hit;
   logic last_pass;

   generate
      if (ABORT_EN) begin : g_abort
         assign abort_hit = act_q_i && intr_q_i && abort_i;
      end else begin : g_no_abort
         logic unused_abort;
         assign unused_abort = abort_i ^ intr_q_i;
         assign abort_hit    = 1'b0;
      end
   endgenerate

   assign end_hit   = act_q_i && (seq_pc_i == end_q_i);
   assign last_pass = (cnt_q_i <= CNT_W'(1));

   always_comb begin
      src_o  = PC_SEQ;
      load_o = 1'b0;
      dec_o  = 1'b0;
      clr_o  = 1'b0;
      if (start_i) begin
         if (cnt_zero_i) begin
            src_o = PC_END;
         end else begin
            load_o = 1'b1;
         end
      end else if (abort_hit) begin
         src_o = PC_END;
         clr_o = 1'b1;
      end else if (end_hit) begin
         if (last_pass) begin
            clr_o = 1'b1;
         end else begin
            dec_o = 1'b1;
            src_o = PC_TOP;
         end
      end
   end

endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs #(
   parameter int PC_W     = 16,
   parameter int CNT_W    = 16,
   parameter bit ABORT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             dec_i,
   input  logic             clr_i,
   input  logic             intr_i,
   input  logic [PC_W-1:0]  top_i,
   input  logic [PC_W-1:0]  end_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [PC_W-1:0]  top_q,
   output logic [PC_W-1:0]  end_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             act_q,
   output logic             intr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q <= '0;
         end_q <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (load_i) begin
         top_q <= top_i;
         end_q <= end_i;
         cnt_q <= cnt_i;
         act_q <= 1'b1;
      end else if (clr_i) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (dec_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   generate
      if (ABORT_EN) begin : g_intr_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               intr_q <= 1'b0;
            end else if (load_i) begin
               intr_q <= intr_i;
            end else if (clr_i) begin
               intr_q <= 1'b0;
            end
         end
      end else begin : g_intr_none
         logic unused_intr;
         assign unused_intr = intr_i;
         assign intr_q      = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int PC_W     = 16,
   parameter int OFFS_W   = 8,
   parameter int IMM_W    = 8,
   parameter int CNT_W    = 16,
   parameter int REG_W    = 32,
   parameter bit ABORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_start_i,
   input  logic              loop_intr_i,
   input  logic              cnt_imm_sel_i,
   input  logic [IMM_W-1:0]  cnt_imm_i,
   input  logic [REG_W-1:0]  cnt_reg_i,
   input  logic [OFFS_W-1:0] end_offs_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              abort_i,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              busy_o
);

   generate
      if (IMM_W >= CNT_W) begin : g_bad_imm
         $error("hwloop_ctrl: IMM_W must be smaller than CNT_W");
      end
      if (REG_W < CNT_W) begin : g_bad_reg
         $error("hwloop_ctrl: REG_W must be at least CNT_W");
      end
      if (OFFS_W > PC_W) begin : g_bad_offs
         $error("hwloop_ctrl: OFFS_W must not exceed PC_W");
      end
   endgenerate

   logic [PC_W-1:0]  seq_pc;
   logic [PC_W-1:0]  end_new;
   logic [PC_W-1:0]  top_q;
   logic [PC_W-1:0]  end_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_new;
   logic             cnt_zero;
   logic             act_q;
   logic             intr_q;
   logic             do_load;
   logic             do_dec;
   logic             do_clr;
   pc_src_t          pc_src;

   assign seq_pc  = pc_i + PC_W'(1);
   assign end_new = pc_i + PC_W'(end_offs_i);

   hwloop_count_sel #(
      .IMM_W (IMM_W),
      .CNT_W (CNT_W),
      .REG_W (REG_W)
   ) u_count (
      .imm_sel_i  (cnt_imm_sel_i),
      .imm_i      (cnt_imm_i),
      .reg_i      (cnt_reg_i),
      .cnt_o      (cnt_new),
      .cnt_zero_o (cnt_zero)
   );

   hwloop_decide #(
      .PC_W     (PC_W),
      .CNT_W    (CNT_W),
      .ABORT_EN (ABORT_EN)
   ) u_decide (
      .start_i    (loop_start_i),
      .cnt_zero_i (cnt_zero),
      .abort_i    (abort_i),
      .act_q_i    (act_q),
      .intr_q_i   (intr_q),
      .seq_pc_i   (seq_pc),
      .end_q_i    (end_q),
      .cnt_q_i    (cnt_q),
      .src_o      (pc_src),
      .load_o     (do_load),
      .dec_o      (do_dec),
      .clr_o      (do_clr)
   );

   hwloop_regs #(
      .PC_W     (PC_W),
      .CNT_W    (CNT_W),
      .ABORT_EN (ABORT_EN)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (do_load),
      .dec_i  (do_dec),
      .clr_i  (do_clr),
      .intr_i (loop_intr_i),
      .top_i  (seq_pc),
      .end_i  (end_new),
      .cnt_i  (cnt_new),
      .top_q  (top_q),
      .end_q  (end_q),
      .cnt_q  (cnt_q),
      .act_q  (act_q),
      .intr_q (intr_q)
   );

   always_comb begin
      unique case (pc_src)
         PC_TOP:  next_pc_o = top_q;
         PC_END:  next_pc_o = end_q;
         default: next_pc_o = seq_pc;
      endcase
   end

   assign busy_o = act_q;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            loop_start_i,
   input logic            cnt_zero,
   input logic [PC_W-1:0] pc_i,
   input logic            abort_i,
   input logic [PC_W-1:0] next_pc_o,
   input logic            busy_o,
   input logic [PC_W-1:0] end_q,
   input logic            intr_q
);

   // R4
   zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_start_i && cnt_zero) |-> (next_pc_o == end_q));

   // R4
   zero_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_start_i && cnt_zero) |=> (busy_o == $past(busy_o)));

   // R5
   start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_start_i && !cnt_zero) |=> busy_o);

   // R11
   idle_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !loop_start_i) |-> (next_pc_o == PC_W'(pc_i + PC_W'(1))));

   // R8
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && intr_q && abort_i && !loop_start_i) |=> !busy_o);

   // R9
   plain_ignores_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !intr_q && abort_i && !loop_start_i
       && (PC_W'(pc_i + PC_W'(1)) != end_q)) |=> busy_o);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.PC_W(PC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .loop_start_i (loop_start_i),
   .cnt_zero     (cnt_zero),
   .pc_i         (pc_i),
   .abort_i      (abort_i),
   .next_pc_o    (next_pc_o),
   .busy_o       (busy_o),
   .end_q        (end_q),
   .intr_q       (intr_q)
);

// File: tb/test_hwloop_ctrl.sv
module test_hwloop_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W   = 8;
   localparam int OFFS_W = 4;
   localparam int IMM_W  = 3;
   localparam int CNT_W  = 5;
   localparam int REG_W  = 8;
   localparam int PCM    = 1 << PC_W;
   localparam int CM     = 1 << CNT_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              loop_start_i;
   logic              loop_intr_i;
   logic              cnt_imm_sel_i;
   logic [IMM_W-1:0]  cnt_imm_i;
   logic [REG_W-1:0]  cnt_reg_i;
   logic [OFFS_W-1:0] end_offs_i;
   logic [PC_W-1:0]   pc_i;
   logic              abort_i;
   logic [PC_W-1:0]   next_pc_o;
   logic              busy_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // reference state
   int m_act = 0, m_intr = 0, m_top = 0, m_end = 0, m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwloop_ctrl #(
      .PC_W(PC_W), .OFFS_W(OFFS_W), .IMM_W(IMM_W),
      .CNT_W(CNT_W), .REG_W(REG_W), .ABORT_EN(1'b1)
   ) i_hwloop_ctrl (
      .clk(clk), .rst_n(rst_n), .loop_start_i(loop_start_i),
      .loop_intr_i(loop_intr_i), .cnt_imm_sel_i(cnt_imm_sel_i),
      .cnt_imm_i(cnt_imm_i), .cnt_reg_i(cnt_reg_i), .end_offs_i(end_offs_i),
      .pc_i(pc_i), .abort_i(abort_i), .next_pc_o(next_pc_o), .busy_o(busy_o)
   );

   task automatic check(string tag, int got, int exp);
      vectors++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step(bit st, bit intr, bit immf, int imm, int regv,
                       int offs, int pc, bit ab, output int nxt);
      int seq, cnt, exp;
      int n_act, n_intr, n_top, n_end, n_cnt;
      string tag;
      @(negedge clk);
      loop_start_i  = st;
      loop_intr_i   = intr;
      cnt_imm_sel_i = immf;
      cnt_imm_i     = IMM_W'(imm);
      cnt_reg_i     = REG_W'(regv);
      end_offs_i    = OFFS_W'(offs);
      pc_i          = PC_W'(pc);
      abort_i       = ab;
      #1;
      seq = (pc + 1) % PCM;
      cnt = immf ? imm + 1 : regv % CM;
      n_act = m_act; n_intr = m_intr; n_top = m_top; n_end = m_end; n_cnt = m_cnt;
      if (st) begin
         if (cnt == 0) begin
            tag = "R4"; exp = m_end;
         end else begin
            tag = m_act ? "R10" : "R5"; exp = seq;
            n_act = 1; n_top = seq; n_end = (pc + offs) % PCM;
            n_cnt = cnt; n_intr = intr;
         end
      end else if (m_act && m_intr && ab) begin
         tag = "R8"; exp = m_end;
         n_act = 0; n_cnt = 0; n_intr = 0;
      end else if (m_act && seq == m_end) begin
         if (m_cnt > 1) begin
            tag = "R6"; exp = m_top; n_cnt = m_cnt - 1;
         end else begin
            tag = "R7"; exp = seq; n_act = 0; n_cnt = 0; n_intr = 0;
         end
      end else begin
         exp = seq;
         tag = (m_act && ab) ? "R9" : "R11";
      end
      check({tag, " next_pc"}, int'(next_pc_o), exp);
      check({tag, " busy"}, int'(busy_o), m_act);
      m_act = n_act; m_intr = n_intr; m_top = n_top; m_end = n_end; m_cnt = n_cnt;
      nxt = exp;
   endtask

   // issue one loop and follow the predicted PC until it leaves the loop
   task automatic run_loop(int pc0, int offs, bit immf, int imm, int regv,
                           bit intr, int abort_at, bit hold_abort);
      int pc, cycles, cnt, end_addr;
      bit ab;
      end_addr = (pc0 + offs) % PCM;
      cnt = immf ? imm + 1 : regv % CM;
      step(1'b1, intr, immf, imm, regv, offs, pc0, 1'b0, pc);
      cycles = 1;
      if (cnt == 0) return;
      while (!(m_act == 0 && pc == end_addr) && cycles < 2000) begin
         ab = hold_abort || (cycles == abort_at);
         step(1'b0, 1'b0, 1'b0, 0, 0, 0, pc, ab, pc);
         cycles++;
      end
      if (abort_at < 0) begin
         if (hold_abort)
            check("R9 cycle count", cycles, 1 + cnt * (offs - 1));
         else if (immf)
            check("R2 cycle count", cycles, 1 + cnt * (offs - 1));
         else
            check("R3 cycle count", cycles, 1 + cnt * (offs - 1));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int pc;
      rst_n = 1'b0; loop_start_i = 1'b0; loop_intr_i = 1'b0;
      cnt_imm_sel_i = 1'b0; cnt_imm_i = '0; cnt_reg_i = '0;
      end_offs_i = '0; pc_i = 8'd100; abort_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 busy", int'(busy_o), 0);
      check("R1 next_pc", int'(next_pc_o), 101);
      step(1'b0, 1'b0, 1'b0, 0, 0, 0, 100, 1'b1, pc);
      // R1 stored end is zero: zero-count setup jumps to 0 (R4)
      step(1'b1, 1'b0, 1'b0, 0, 0, 5, 40, 1'b0, pc);
      check("R1 end reset", pc, 0);

      // R2 immediate sweep over every count and offset
      for (int imm = 0; imm < (1 << IMM_W); imm++)
         for (int offs = 2; offs < (1 << OFFS_W); offs++)
            run_loop((imm * 37 + offs * 11) % PCM, offs, 1'b1, imm, 0, 1'b0, -1, 1'b0);

      // R3 register sweep, upper bits set on alternate values
      for (int v = 0; v < CM; v++) begin
         run_loop(60 + v, 3, 1'b0, 0, v, 1'b0, -1, 1'b0);
         run_loop(30, 2, 1'b0, 0, v + CM * (1 + v % 7), 1'b0, -1, 1'b0);
      end

      // R4 zero count after a finished loop goes to that loop's end
      run_loop(10, 4, 1'b1, 1, 0, 1'b0, -1, 1'b0);
      step(1'b1, 1'b0, 1'b0, 0, 8'hE0, 6, 90, 1'b0, pc);
      check("R4 stored end", pc, 14);

      // wrap of loop end past the top of the address space
      run_loop(250, 12, 1'b1, 2, 0, 1'b0, -1, 1'b0);
      run_loop(253, 15, 1'b0, 0, 3, 1'b1, -1, 1'b0);

      // R8 abort at each cycle of an interruptible loop
      for (int k = 1; k < 12; k++)
         run_loop(120, 4, 1'b1, 3, 0, 1'b1, k, 1'b0);

      // R9 plain loop with abort held high completes normally
      run_loop(140, 5, 1'b1, 4, 0, 1'b0, -1, 1'b1);
      run_loop(150, 3, 1'b0, 0, 9, 1'b0, -1, 1'b1);

      // R10 setup on a loop-end cycle while busy, with abort raised
      step(1'b1, 1'b1, 1'b1, 3, 0, 5, 20, 1'b0, pc);
      while (pc != 24) step(1'b0, 1'b0, 1'b0, 0, 0, 0, pc, 1'b0, pc);
      step(1'b1, 1'b1, 1'b1, 1, 0, 3, 24, 1'b1, pc);
      check("R10 replaced", pc, 25);
      while (!(m_act == 0 && pc == 27))
         step(1'b0, 1'b0, 1'b0, 0, 0, 0, pc, 1'b0, pc);
      check("R10 new end reached", pc, 27);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule